// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column address of a synchronous DRAM burst, one address per clock, after a start strobe. The burst length comes from a three-bit length code and the order comes from a one-bit order select. Linear order counts upward inside an aligned window the size of the burst. Cross order combines the starting offset with the beat index by XOR. A full-page linear burst visits every column of the row once and wraps at the row end. The block flags a bad mode setting and does not start a burst for it. A stop input ends a burst on the beat where it is raised.

The block also times the data-mask input. For writes, a mask acts on the beat in which it arrives. For reads, a mask becomes an output-enable kill a fixed number of cycles later. A controller uses the column and beat strobes to drive the array. It feeds the mask kill to its read-data output driver.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and right after it, beat_valid_o, last_o, mode_err_o, wr_mask_o and rd_oe_kill_o are all 0.
- R2: A start with length code 000, 001, 010 or 011 gives 1, 2, 4 or 8 beats. beat_valid_o is high on consecutive cycles, starting in the cycle after the start edge.
- R3: With order select 0 (linear), beat k puts out (S - S mod L) + ((S mod L + k) mod L). Here S is the start column and L is the burst length.
- R4: With order select 1 (cross), beat k puts out (S - S mod L) + ((S mod L) XOR k).
- R5: Length code 111 with order select 0 gives 2^COL_W beats (256 by default). Linear order wraps modulo the page width.
- R6: The length codes 100, 101 and 110 are rejected, and so is code 111 with order select 1. mode_err_o is then high for exactly the one cycle after the start edge. No beat follows, and any running burst is dropped.
- R7: last_o is high on the final beat of a burst that runs to its full length, and on no other beat.
- R8: A beat during which stop_i is high is marked by last_o. beat_valid_o is low in the next cycle unless a new start is given.
- R9: A start during a running burst drops that burst. The new burst's beat 0 appears in the next cycle.
- R10: wr_mask_o follows dqm_i in the same cycle during the beats of a write burst (is_write_i high at the start). It is 0 at all other times.
- R11: rd_oe_kill_o equals the value dqm_i had at the rising edge two edges earlier (RD_LAT = 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst at the next edge |
| start_col_i | input | COL_W | First column of the burst |
| is_write_i | input | 1 | Burst is a write (sampled with start_i) |
| stop_i | input | 1 | End the burst on the current beat |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 linear order, 1 cross (XOR) order |
| dqm_i | input | 1 | Data mask input |
| col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A burst beat is present this cycle |
| last_o | output | 1 | Current beat is the final one |
| mode_err_o | output | 1 | Previous start used a rejected mode |
| wr_mask_o | output | 1 | Mask the write data of this beat |
| rd_oe_kill_o | output | 1 | Force the read output driver off |

## Verification
The bench keeps the defaults COL_W = 8 and RD_LAT = 2. The 256-beat full-page burst can therefore run to completion and wrap through column 0 within a few hundred cycles. The mask delay under test is the two-cycle read latency itself. Eight-bit columns also leave upper bits above the longest fixed window, so random start columns show whether the aligned-window bits are kept while the low bits wrap.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_order_e;

    localparam logic [2:0] LEN_ONE   = 3'b000;
    localparam logic [2:0] LEN_TWO   = 3'b001;
    localparam logic [2:0] LEN_FOUR  = 3'b010;
    localparam logic [2:0] LEN_EIGHT = 3'b011;
    localparam logic [2:0] LEN_PAGE  = 3'b111;

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code_i,
    input  logic             order_i,
    output logic [COL_W-1:0] len_mask_o,
    output logic             legal_o
);

    localparam logic [COL_W-1:0] PAGE_MASK = '1;

    always_comb begin
        len_mask_o = '0;
        legal_o    = 1'b0;
        case (len_code_i)
            LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT: begin
                len_mask_o = COL_W'((32'd1 << len_code_i[1:0]) - 32'd1);
                legal_o    = 1'b1;
            end
            LEN_PAGE: begin
                len_mask_o = PAGE_MASK;
                legal_o    = (burst_order_e'(order_i) == ORD_LINEAR);
            end
            default: begin
                len_mask_o = '0;
                legal_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             order_i,
    input  logic             is_write_i,
    input  logic             stop_i,
    input  logic             legal_i,
    input  logic [COL_W-1:0] len_mask_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_valid_o,
    output logic             last_o,
    output logic             err_o,
    output logic             write_burst_o
);

    typedef struct packed {
        logic             active;
        logic             write;
        burst_order_e     order;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] cnt;
        logic             err;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       at_end;
    logic [COL_W-1:0] off_w, step_w;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        at_end  = s_q.active && ((s_q.cnt == s_q.mask) || stop_i);
        if (start_i) begin
            if (legal_i) begin
                s_d.active = 1'b1;
                s_d.write  = is_write_i;
                s_d.order  = burst_order_e'(order_i);
                s_d.base   = start_col_i;
                s_d.mask   = len_mask_i;
                s_d.cnt    = '0;
            end else begin
                s_d.active = 1'b0;
                s_d.write  = 1'b0;
                s_d.err    = 1'b1;
            end
        end else if (s_q.active) begin
            if (at_end) begin
                s_d.active = 1'b0;
                s_d.write  = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        off_w  = s_q.base & s_q.mask;
        step_w = (s_q.order == ORD_XOR) ? (off_w ^ s_q.cnt) : (off_w + s_q.cnt);
        col_o  = (s_q.base & ~s_q.mask) | (step_w & s_q.mask);
    end

    assign beat_valid_o  = s_q.active;
    assign last_o        = at_end;
    assign err_o         = s_q.err;
    assign write_burst_o = s_q.active && s_q.write;

    p_last_needs_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_valid_o);

    p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && stop_i && !start_i) |=> !beat_valid_o);

    p_cnt_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> (s_q.cnt <= s_q.mask));

    p_err_no_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !beat_valid_o);

endmodule

// File: rtl/dqm_timing.sv
module dqm_timing #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dqm_i,
    input  logic beat_valid_i,
    input  logic write_burst_i,
    output logic wr_mask_o,
    output logic rd_oe_kill_o
);

    typedef struct packed {
        logic [RD_LAT-1:0] pipe;
    } dqm_state_t;

    dqm_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.pipe    = s_q.pipe << 1;
        s_d.pipe[0] = dqm_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_mask_o    = dqm_i && write_burst_i;
    assign rd_oe_kill_o = s_q.pipe[RD_LAT-1];

    always_comb begin
        if (wr_mask_o) begin
            p_wr_mask_in_beat_r10: assert (beat_valid_i && dqm_i);
        end
    end

    generate
        if (RD_LAT == 2) begin : g_lat2_chk
            logic [1:0] seen_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    seen_q <= '0;
                end else if (seen_q != 2'd2) begin
                    seen_q <= seen_q + 2'd1;
                end
            end
            p_rd_kill_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (seen_q == 2'd2) |-> (rd_oe_kill_o == $past(dqm_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int RD_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             is_write_i,
    input  logic             stop_i,
    input  logic [2:0]       len_code_i,
    input  logic             order_i,
    input  logic             dqm_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_valid_o,
    output logic             last_o,
    output logic             mode_err_o,
    output logic             wr_mask_o,
    output logic             rd_oe_kill_o
);

    logic [COL_W-1:0] len_mask_w;
    logic             legal_w;
    logic             write_burst_w;

    burst_mode_decode #(.COL_W(COL_W)) u_decode (
        .len_code_i (len_code_i),
        .order_i    (order_i),
        .len_mask_o (len_mask_w),
        .legal_o    (legal_w)
    );

    burst_col_seq #(.COL_W(COL_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_col_i   (start_col_i),
        .order_i       (order_i),
        .is_write_i    (is_write_i),
        .stop_i        (stop_i),
        .legal_i       (legal_w),
        .len_mask_i    (len_mask_w),
        .col_o         (col_o),
        .beat_valid_o  (beat_valid_o),
        .last_o        (last_o),
        .err_o         (mode_err_o),
        .write_burst_o (write_burst_w)
    );

    dqm_timing #(.RD_LAT(RD_LAT)) u_dqm (
        .clk           (clk),
        .rst_n         (rst_n),
        .dqm_i         (dqm_i),
        .beat_valid_i  (beat_valid_o),
        .write_burst_i (write_burst_w),
        .wr_mask_o     (wr_mask_o),
        .rd_oe_kill_o  (rd_oe_kill_o)
    );

    p_start_gives_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && legal_w) |=> (beat_valid_o && !mode_err_o));

    p_bad_mode_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !legal_w) |=> (mode_err_o && !beat_valid_o));

    p_page_linear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (len_code_i == LEN_PAGE) && order_i) |=> !beat_valid_o);

endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

    localparam int COL_W  = 8;
    localparam int RD_LAT = 2;
    localparam int PAGE   = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             is_write_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [2:0]       len_code_i = 3'b000;
    logic             order_i = 1'b0;
    logic             dqm_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_valid_o, last_o, mode_err_o, wr_mask_o, rd_oe_kill_o;

    always #5 clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W), .RD_LAT(RD_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .is_write_i(is_write_i), .stop_i(stop_i), .len_code_i(len_code_i),
        .order_i(order_i), .dqm_i(dqm_i), .col_o(col_o),
        .beat_valid_o(beat_valid_o), .last_o(last_o), .mode_err_o(mode_err_o),
        .wr_mask_o(wr_mask_o), .rd_oe_kill_o(rd_oe_kill_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    bit m_act = 0, m_seq = 1, m_wr = 0, m_err = 0, m_restart = 0;
    int m_base = 0, m_len = 1, m_k = 0;
    bit h1 = 0, h2 = 0;

    function automatic int burst_len(input logic [2:0] code, input logic ord);
        case (code)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return ord ? 0 : PAGE;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_col(input int base, input int len, input bit seq, input int k);
        int lo, hi;
        lo = base % len;
        hi = base - lo;
        if (seq) return hi + ((lo + k) % len);
        return hi + (lo ^ k);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic cycle(input bit st, input int col, input logic [2:0] code,
                         input bit ord, input bit wr, input bit stp, input bit dq);
        int len;
        @(negedge clk);
        start_i = st; start_col_i = COL_W'(col); len_code_i = code;
        order_i = ord; is_write_i = wr; stop_i = stp; dqm_i = dq;
        #4;
        chk(m_restart ? "R9 valid after restart" : "R2 beat valid", int'(beat_valid_o), int'(m_act));
        if (m_act) begin
            if (m_len == PAGE) chk("R5 page column", int'(col_o), exp_col(m_base, m_len, 1, m_k));
            else if (m_seq)    chk("R3 linear column", int'(col_o), exp_col(m_base, m_len, 1, m_k));
            else               chk("R4 cross column", int'(col_o), exp_col(m_base, m_len, 0, m_k));
        end
        if (stp && m_act) chk("R8 stop marks last", int'(last_o), 1);
        else chk("R7 last flag", int'(last_o), int'(m_act && (m_k == m_len - 1)));
        chk("R6 mode error", int'(mode_err_o), int'(m_err));
        chk("R10 write mask", int'(wr_mask_o), int'(dq && m_act && m_wr));
        chk("R11 read kill", int'(rd_oe_kill_o), int'(h2));
        @(posedge clk);
        h2 = h1; h1 = dq;
        m_err = 0; m_restart = 0;
        if (st) begin
            len = burst_len(code, ord);
            if (len != 0) begin
                m_restart = m_act;
                m_act = 1; m_base = col; m_len = len; m_seq = !ord; m_wr = wr; m_k = 0;
            end else begin
                m_act = 0; m_err = 1; m_wr = 0;
            end
        end else if (m_act) begin
            if (m_k == m_len - 1 || stp) m_act = 0;
            else m_k++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 3'b000, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        // R1: reset state
        repeat (3) @(negedge clk);
        #4;
        chk("R1 reset valid", int'(beat_valid_o), 0);
        chk("R1 reset last", int'(last_o), 0);
        chk("R1 reset err", int'(mode_err_o), 0);
        chk("R1 reset wmask", int'(wr_mask_o), 0);
        chk("R1 reset kill", int'(rd_oe_kill_o), 0);
        @(negedge clk); rst_n = 1'b1;
        #4;
        chk("R1 after reset valid", int'(beat_valid_o), 0);
        chk("R1 after reset kill", int'(rd_oe_kill_o), 0);

        // R3: linear 8 from 0x35 -> 35 36 37 30 31 32 33 34
        cycle(1, 8'h35, 3'b011, 0, 0, 0, 0);
        idle(9);
        // R4: cross 8 from 0x35 -> 35 34 37 36 31 30 33 32
        cycle(1, 8'h35, 3'b011, 1, 1, 0, 1);
        idle(9);
        // R2: each fixed length
        for (int c = 0; c < 4; c++) begin
            cycle(1, 8'hA6, 3'(c), 0, 0, 0, 0);
            idle(9);
        end
        // R5: full page from 0xFE wraps through 0
        cycle(1, 8'hFE, 3'b111, 0, 1, 0, 1);
        idle(PAGE + 2);
        // R6: rejected modes
        cycle(1, 8'h10, 3'b111, 1, 0, 0, 0);
        cycle(1, 8'h10, 3'b100, 0, 0, 0, 0);
        cycle(1, 8'h10, 3'b101, 1, 0, 0, 0);
        cycle(1, 8'h10, 3'b110, 0, 0, 0, 0);
        idle(2);
        // R8: stop on third beat
        cycle(1, 8'h40, 3'b011, 0, 0, 0, 0);
        idle(2);
        cycle(0, 0, 3'b000, 0, 0, 1, 0);
        idle(3);
        // R9: restart in mid burst
        cycle(1, 8'h50, 3'b011, 1, 0, 0, 0);
        idle(2);
        cycle(1, 8'h63, 3'b010, 0, 1, 0, 1);
        idle(6);
        // R11: isolated mask pulses
        cycle(0, 0, 3'b000, 0, 0, 0, 1);
        idle(4);

        for (int i = 0; i < 6000; i++) begin
            bit st, ord, wr, stp, dq;
            logic [2:0] code;
            int col;
            st   = m_act ? ($urandom_range(0, 39) == 0) : ($urandom_range(0, 5) == 0);
            code = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(0, 3)) : 3'($urandom_range(4, 7));
            if ($urandom_range(0, 60) == 0) code = 3'b111;
            ord  = 1'($urandom_range(0, 1));
            wr   = 1'($urandom_range(0, 1));
            stp  = ($urandom_range(0, 29) == 0);
            dq   = 1'($urandom_range(0, 1));
            col  = $urandom_range(0, PAGE - 1);
            cycle(st, col, code, ord, wr, stp, dq);
        end
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule